// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Unit

This block picks the smaller or the larger of two IEEE-754 binary operands. The operand width is set by a parameter: single precision (32 bits) or double precision (64 bits). An op-select input chooses minimum or maximum. The result and a five-bit status-update vector are registered once and appear one clock after the operands. The vector is meant to be OR-ed into a sticky status register that lives elsewhere. This block only produces the per-operation flag pulses.

The block's distinctive behaviour is how it treats NaN inputs. If one operand is a NaN, that operand is dropped and the other operand is returned bit for bit. If both operands are NaN, the result is an all-ones word. Any signalling NaN raises the invalid flag. This holds even when the other operand is returned. Quiet NaNs raise nothing. Ordinary numbers, infinities, subnormals and the two zeros are ordered by their exact value, and -0 is ordered below +0.

Top module: `fp_minmax_unit`

## Requirements
- R1: While rst_ni is low, result_o and flags_o are all zeros.
- R2: result_o and flags_o reflect the operands and op_max_i that were present at the previous rising clock edge. Before that edge they hold their old value.
- R3: When neither operand is NaN, op_max_i=0 returns the numerically smaller operand and op_max_i=1 returns the larger one. Infinities and subnormals are compared by exact value, with no flush to zero.
- R4: -0 is ordered below +0. Minimum of (+0, -0) returns -0 (sign bit set), and maximum returns +0.
- R5: If exactly one operand is NaN (exponent all ones, fraction non-zero), result_o equals the other operand unchanged.
- R6: If both operands are NaN, result_o is all ones across the full word width.
- R7: flags_o[1] (invalid) is 1 when either operand is a signalling NaN, that is a NaN whose top fraction bit (bit 22 single, bit 51 double) is 0. This includes the case where the other operand is returned.
- R8: Quiet NaN operands (top fraction bit 1), one or two of them, leave flags_o[1] at 0.
- R9: flags_o[2] (divide-by-zero), flags_o[3] (overflow), flags_o[4] (underflow) and flags_o[5] (inexact) are always 0.
- R10: With DOUBLE=1 the unit applies R3 to R9 to 64-bit operands, with an 11-bit exponent and a 52-bit fraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | W (32 or 64) | First operand |
| b_i | input | W (32 or 64) | Second operand |
| op_max_i | input | 1 | 0 selects minimum, 1 selects maximum |
| result_o | output | W | Selected value, registered |
| flags_o | output | 5 (bits 5:1) | Status-update pulses: bit 1 invalid, bits 2 to 5 divide-by-zero, overflow, underflow, inexact |

## Verification
Value selection and invalid signalling can happen in the same cycle when a signalling NaN meets an ordinary number. In that case the other operand must come out unchanged, and flags_o[1] must rise in that same output cycle. The bench provokes this by sweeping every pairing of a corner set that holds both NaN kinds, both zeros, both infinities and a subnormal, under both op selects. It also injects NaN exponents into random operands at both precisions. Result and flags are judged separately, against a bench model that orders operands by a sign-folded integer key.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  localparam int unsigned FLAG_LO  = 1;
  localparam int unsigned FLAG_HI  = 5;
  localparam int unsigned FLAG_INV = 1;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
  } opnd_cls_t;
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify #(
  parameter int unsigned W      = 32,
  parameter int unsigned FRAC_W = 23
) (
  input  logic [W-1:0]          op_i,
  output fpmm_pkg::opnd_cls_t   cls_o
);
  localparam int unsigned EXP_W = W - 1 - FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = op_i[W-2 -: EXP_W];
  assign frac_f = op_i[FRAC_W-1:0];

  always_comb begin
    cls_o.is_nan  = (&exp_f) && (|frac_f);
    cls_o.is_snan = cls_o.is_nan && !frac_f[FRAC_W-1];
  end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         a_lt_b_o
);
  logic         sa, sb;
  logic [W-2:0] ma, mb;

  assign sa = a_i[W-1];
  assign sb = b_i[W-1];
  assign ma = a_i[W-2:0];
  assign mb = b_i[W-2:0];

  // sign-magnitude order; -0 sorts below +0 through the sign term
  always_comb begin
    if (sa != sb)  a_lt_b_o = sa;
    else if (sa)   a_lt_b_o = (ma > mb);
    else           a_lt_b_o = (ma < mb);
  end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit #(
  parameter bit DOUBLE = 1'b0,
  localparam int unsigned W      = DOUBLE ? 64 : 32,
  localparam int unsigned FRAC_W = DOUBLE ? 52 : 23
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  input  logic                 op_max_i,
  output logic [W-1:0]         result_o,
  output logic [fpmm_pkg::FLAG_HI:fpmm_pkg::FLAG_LO] flags_o
);
  import fpmm_pkg::*;

  localparam int unsigned N_OPS = 2;

  logic [W-1:0] opnd [N_OPS];
  opnd_cls_t    cls  [N_OPS];
  logic         a_lt_b;
  logic [W-1:0] res_d;
  logic [FLAG_HI:FLAG_LO] flags_d;

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fpmm_classify #(.W(W), .FRAC_W(FRAC_W)) u_cls (
      .op_i  (opnd[g]),
      .cls_o (cls[g])
    );
  end

  fpmm_order #(.W(W)) u_order (
    .a_i      (a_i),
    .b_i      (b_i),
    .a_lt_b_o (a_lt_b)
  );

  always_comb begin
    if (cls[0].is_nan && cls[1].is_nan) res_d = '1;
    else if (cls[0].is_nan)             res_d = b_i;
    else if (cls[1].is_nan)             res_d = a_i;
    else                                res_d = (op_max_i ^ a_lt_b) ? a_i : b_i;
  end

  always_comb begin
    flags_d           = '0;
    flags_d[FLAG_INV] = cls[0].is_snan | cls[1].is_snan;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      result_o <= res_d;
      flags_o  <= flags_d;
    end
  end
endmodule

// File: rtl/fpmm_chk.sv
module fpmm_chk #(
  parameter int unsigned W      = 32,
  parameter int unsigned FRAC_W = 23
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] result_o,
  input logic [5:1]   flags_o
);
  localparam int unsigned EXP_W = W - 1 - FRAC_W;

  logic         seen;
  logic [W-1:0] a_q, b_q;
  logic         an, bn, as, bs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen <= 1'b0;
      a_q  <= '0;
      b_q  <= '0;
    end else begin
      seen <= 1'b1;
      a_q  <= a_i;
      b_q  <= b_i;
    end
  end

  assign an = (&a_q[W-2 -: EXP_W]) && (|a_q[FRAC_W-1:0]);
  assign bn = (&b_q[W-2 -: EXP_W]) && (|b_q[FRAC_W-1:0]);
  assign as = an && !a_q[FRAC_W-1];
  assign bs = bn && !b_q[FRAC_W-1];

  // R6
  both_nan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && an && bn) |-> (result_o == {W{1'b1}}));

  // R5
  lone_nan_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && an && !bn) |-> (result_o == b_q));

  // R5
  lone_nan_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && bn && !an) |-> (result_o == a_q));

  // R3
  pick_operand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && !an && !bn) |-> (result_o == a_q || result_o == b_q));

  // R7
  invalid_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> (flags_o[1] == (as | bs)));

  // R9
  other_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[5:2] == 4'b0000);
endmodule

bind fp_minmax_unit fpmm_chk #(.W(W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_i      (a_i),
  .b_i      (b_i),
  .result_o (result_o),
  .flags_o  (flags_o)
);

// File: tb/sim_fp_minmax_unit.sv
module sim_fp_minmax_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] sa, sb;
  logic [63:0] da, db;
  logic        op;
  logic [31:0] s_res;
  logic [63:0] d_res;
  logic [5:1]  s_flg, d_flg;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fp_minmax_unit #(.DOUBLE(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(sa), .b_i(sb), .op_max_i(op),
    .result_o(s_res), .flags_o(s_flg));

  fp_minmax_unit #(.DOUBLE(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(da), .b_i(db), .op_max_i(op),
    .result_o(d_res), .flags_o(d_flg));

  function automatic bit is_nan(logic [63:0] x, bit dbl);
    if (dbl) return (x[62:52] == 11'h7ff) && (x[51:0] != 0);
    return (x[30:23] == 8'hff) && (x[22:0] != 0);
  endfunction

  function automatic bit is_snan(logic [63:0] x, bit dbl);
    return is_nan(x, dbl) && !(dbl ? x[51] : x[22]);
  endfunction

  // sign-folded key: unsigned order of keys equals numeric order
  function automatic logic [63:0] okey(logic [63:0] x, bit dbl);
    if (dbl) return x[63] ? ~x : (x | 64'h8000_0000_0000_0000);
    return {32'h0, x[31] ? ~x[31:0] : (x[31:0] | 32'h8000_0000)};
  endfunction

  function automatic logic [63:0] ref_res(logic [63:0] a, logic [63:0] b, bit mx, bit dbl);
    bit na = is_nan(a, dbl);
    bit nb = is_nan(b, dbl);
    if (na && nb) return dbl ? 64'hffff_ffff_ffff_ffff : 64'h0000_0000_ffff_ffff;
    if (na) return b;
    if (nb) return a;
    if (okey(a, dbl) < okey(b, dbl)) return mx ? b : a;
    if (okey(b, dbl) < okey(a, dbl)) return mx ? a : b;
    return a;
  endfunction

  function automatic string tag_of(logic [63:0] a, logic [63:0] b, bit dbl);
    bit na = is_nan(a, dbl);
    bit nb = is_nan(b, dbl);
    bit za = dbl ? (a[62:0] == 0) : (a[30:0] == 0);
    bit zb = dbl ? (b[62:0] == 0) : (b[30:0] == 0);
    if (na && nb) return "R6";
    if (na || nb) return "R5";
    if (za && zb) return "R4";
    return "R3";
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%h expected 0x%h", tag, act, exp);
    end
  endtask

  task automatic judge(logic [63:0] a, logic [63:0] b, logic [63:0] res,
                       logic [5:1] flg, bit dbl);
    string t = tag_of(a, b, dbl);
    bit inv = is_snan(a, dbl) || is_snan(b, dbl);
    if (dbl) t = {t, " R10"};
    check(t, res, ref_res(a, b, op, dbl));
    check(inv ? (dbl ? "R7 R10" : "R7") : (dbl ? "R8 R10" : "R8"), 64'(flg[1]), 64'(inv));
    check(dbl ? "R9 R10" : "R9", 64'(flg[5:2]), 64'h0);
  endtask

  task automatic run_vec(logic [31:0] a32, logic [31:0] b32,
                         logic [63:0] a64, logic [63:0] b64, bit mx);
    sa = a32; sb = b32; da = a64; db = b64; op = mx;
    @(posedge clk);
    @(negedge clk);
    judge({32'h0, a32}, {32'h0, b32}, {32'h0, s_res}, s_flg, 1'b0);
    judge(a64, b64, d_res, d_flg, 1'b1);
  endtask

  logic [31:0] sc [10] = '{32'h0000_0000, 32'h8000_0000, 32'h3f80_0000, 32'hbf80_0000,
                          32'h7f80_0000, 32'hff80_0000, 32'h7fc0_0000, 32'h7f80_0001,
                          32'h0000_0001, 32'h7f7f_ffff};
  logic [63:0] dc [10] = '{64'h0, 64'h8000_0000_0000_0000, 64'h3ff0_0000_0000_0000,
                          64'hbff0_0000_0000_0000, 64'h7ff0_0000_0000_0000,
                          64'hfff0_0000_0000_0000, 64'h7ff8_0000_0000_0000,
                          64'h7ff0_0000_0000_0001, 64'h1, 64'h7fef_ffff_ffff_ffff};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    sa = 32'h3f80_0000; sb = 32'h4000_0000; da = '1; db = '1; op = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {32'h0, s_res}, 64'h0);
    check("R1", d_res, 64'h0);
    check("R1", 64'({s_flg, d_flg}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: outputs follow inputs of the previous edge only
    sa = 32'h3f80_0000; sb = 32'hbf80_0000; op = 1'b0;
    #1 check("R2", {32'h0, s_res}, 64'h0000_0000_4000_0000);
    @(posedge clk);
    @(negedge clk);
    check("R2", {32'h0, s_res}, 64'h0000_0000_bf80_0000);
    // R4 explicit signed-zero ordering
    run_vec(32'h0, 32'h8000_0000, 64'h0, 64'h8000_0000_0000_0000, 1'b0);
    check("R4", {32'h0, s_res}, 64'h8000_0000);
    run_vec(32'h8000_0000, 32'h0, 64'h8000_0000_0000_0000, 64'h0, 1'b1);
    check("R4", d_res, 64'h0);
    // R7 signalling NaN alongside a number
    run_vec(32'h7f80_0001, 32'h3f80_0000, 64'h7ff7_0000_0000_0000, 64'h3f80_0000_0000_0000, 1'b0);
    check("R7", {32'h0, s_res, 27'h0, s_flg}, {32'h0, 32'h3f80_0000, 27'h0, 5'b00001});
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++)
        for (int m = 0; m < 2; m++)
          run_vec(sc[i], sc[j], dc[i], dc[j], bit'(m));
    for (int k = 0; k < 1500; k++) begin
      logic [31:0] ra = $urandom, rb = $urandom;
      logic [63:0] xa = {$urandom, $urandom}, xb = {$urandom, $urandom};
      if ($urandom % 5 == 0) ra[30:23] = 8'hff;
      if ($urandom % 5 == 0) rb[30:23] = 8'hff;
      if ($urandom % 5 == 0) xa[62:52] = 11'h7ff;
      if ($urandom % 5 == 0) xb[62:52] = 11'h7ff;
      if ($urandom % 7 == 0) rb = ra ^ 32'h8000_0000;
      run_vec(ra, rb, xa, xb, bit'($urandom % 2));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule